// File: doc/BRIEF.md
# Multi-Note Tone Player

The block plays a single tone, or a silence, for a fixed number of clock cycles. A requester presents a 3-bit note number with a valid strobe. The block takes it on a cycle where its ready output is also high, stores the number and starts a duration timer. Seven internal square-wave generators restart at that moment. A selector puts the chosen generator's wave onto one 1-bit output. Note number zero selects nothing, so the output stays low for the whole duration.

The duration and the seven half-period counts are static inputs that are set up before reset is released. Each half-period field sets the number of clock cycles between toggles of its generator. The stored note number is brought out on a debug port. Ready is a registered phase flag. It never looks at the valid input, so a requester may hold valid high and issue notes back to back.

Top module: `tone_player`

## Requirements
- R1: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. After that edge `held_note` equals the `req_note` value of the request and `req_ready` is low.
- R2: After a request is taken, `req_ready` stays low for exactly max(`dur_cycles`, 1) cycles and then returns high.
- R3: While the block is busy, `req_valid` and `req_note` are ignored and `held_note` does not change. While the block is idle with `req_valid` low, `req_ready` stays high.
- R4: Note number 0 is a rest: `tone_out` stays low for the whole duration.
- R5: For note n (1 to 7), the half-period is P = max(field, 1). The field is `half_periods[16n-1:16(n-1)]`. After j playing cycles, `tone_out` equals floor(j/P) mod 2, so the wave starts low.
- R6: Every taken request restarts the generators. A note taken back to back begins its wave from low with a fresh phase.
- R7: Whenever `req_ready` is high, `tone_out` is low.
- R8: `held_note` keeps its value from one taken request until the next one.
- R9: While `rst_n` is low, `req_ready` is 1, `tone_out` is 0 and `held_note` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Note request valid |
| req_note | input | 3 | Requested note number (0 means rest) |
| req_ready | output | 1 | Block is idle and can take a request |
| dur_cycles | input | 16 | Note duration in cycles (0 is treated as 1) |
| half_periods | input | 112 | Seven 16-bit half-period counts; note n uses field n-1 |
| tone_out | output | 1 | Square-wave note output |
| held_note | output | 3 | Debug view of the stored note number |

## Verification
The checker tests the following on every cycle:
- the handshake turns into a busy phase;
- the captured note number is correct;
- the stored note holds between requests;
- the output is silent during rests and while idle;
- ready stays high while idle with valid low;
- the busy window has the right length, measured with a counter rather than a long delay.

The wave shape, the phase restart on a back-to-back note and the mapping from note number to half-period field can only be shown by the bench. Its cycle-level model follows chosen sequences of notes, half-periods and durations, including the zero and one cycle edge cases.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_PLAY = 1'b1
  } phase_e;

  localparam int unsigned TP_CNT_W     = 16;
  localparam int unsigned TP_NUM_TONES = 7;

endpackage

// File: rtl/tone_gen.sv
module tone_gen #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic [CNT_W-1:0] half_period,
  output logic             wave
);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             wave_q, wave_d;

  // a zero half-period behaves like one cycle
  assign lim = (half_period == '0) ? '0 : half_period - 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    wave_d = wave_q;
    if (restart) begin
      cnt_d  = '0;
      wave_d = 1'b0;
    end else if (advance) begin
      if (cnt_q == lim) begin
        cnt_d  = '0;
        wave_d = ~wave_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (restart || advance) begin
      cnt_q  <= cnt_d;
      wave_q <= wave_d;
    end
  end

  assign wave = wave_q;

endmodule

// File: rtl/dur_timer.sv
module dur_timer
  import tone_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] dur,
  output logic             active
);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             cnt_en;

  assign last = (dur == '0) ? '0 : dur - 1'b1;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d   = PH_PLAY;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      PH_PLAY: begin
        cnt_en = 1'b1;
        if (cnt_q == last) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active = (ph_q == PH_PLAY);

endmodule

// File: rtl/tone_select.sv
module tone_select #(
  parameter int unsigned NUM_TONES = 7,
  parameter int unsigned SEL_W     = 3
) (
  input  logic [NUM_TONES-1:0] waves,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 en,
  output logic                 out
);

  // selector value 0 picks no generator (rest)
  always_comb begin
    out = 1'b0;
    for (int i = 0; i < NUM_TONES; i++) begin
      if (sel == SEL_W'(i + 1)) out = waves[i];
    end
    out = out & en;
  end

endmodule

// File: rtl/tone_player.sv
module tone_player #(
  parameter int unsigned CNT_W     = tone_pkg::TP_CNT_W,
  parameter int unsigned NUM_TONES = tone_pkg::TP_NUM_TONES,
  localparam int unsigned SEL_W    = $clog2(NUM_TONES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [SEL_W-1:0]           req_note,
  output logic                       req_ready,
  input  logic [CNT_W-1:0]           dur_cycles,
  input  logic [NUM_TONES*CNT_W-1:0] half_periods,
  output logic                       tone_out,
  output logic [SEL_W-1:0]           held_note
);

  logic                 active;
  logic                 accept;
  logic [SEL_W-1:0]     note_q, note_d;
  logic [NUM_TONES-1:0] waves;

  // ready comes from a register only; valid never feeds it
  assign req_ready = ~active;
  assign accept    = req_valid & req_ready;

  always_comb begin
    note_d = note_q;
    if (accept) note_d = req_note;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      note_q <= '0;
    end else if (accept) begin
      note_q <= note_d;
    end
  end

  dur_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .dur    (dur_cycles),
    .active (active)
  );

  for (genvar g = 0; g < NUM_TONES; g++) begin : g_gen
    tone_gen #(.CNT_W(CNT_W)) u_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (accept),
      .advance     (active),
      .half_period (half_periods[g*CNT_W +: CNT_W]),
      .wave        (waves[g])
    );
  end

  tone_select #(.NUM_TONES(NUM_TONES), .SEL_W(SEL_W)) u_sel (
    .waves (waves),
    .sel   (note_q),
    .en    (active),
    .out   (tone_out)
  );

  assign held_note = note_q;

endmodule

// File: rtl/tone_player_chk.sv
module tone_player_chk #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned NUM_TONES = 7,
  localparam int unsigned SEL_W    = $clog2(NUM_TONES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [SEL_W-1:0] req_note,
  input logic             req_ready,
  input logic [CNT_W-1:0] dur_cycles,
  input logic             tone_out,
  input logic [SEL_W-1:0] held_note
);

  logic           accept;
  logic [CNT_W:0] run_len;
  logic [CNT_W:0] exp_len;

  assign accept  = req_valid && req_ready;
  assign exp_len = (dur_cycles == '0) ? (CNT_W+1)'(1) : {1'b0, dur_cycles};

  // counts busy cycles since the last taken request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (accept) begin
      run_len <= '0;
    end else if (!req_ready) begin
      run_len <= run_len + 1'b1;
    end
  end

  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (held_note == $past(req_note)));

  a_r2_duration: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (run_len == exp_len));

  a_r3_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> req_ready);

  a_r4_rest_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (held_note == '0) |-> !tone_out);

  a_r7_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !tone_out);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(held_note));

endmodule

bind tone_player tone_player_chk #(.CNT_W(CNT_W), .NUM_TONES(NUM_TONES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_note   (req_note),
  .req_ready  (req_ready),
  .dur_cycles (dur_cycles),
  .tone_out   (tone_out),
  .held_note  (held_note)
);

// File: tb/test_tone_player.sv
`timescale 1ns/1ps
module test_tone_player;

  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic [2:0]   req_note;
  logic         req_ready;
  logic [15:0]  dur_cycles;
  logic [111:0] half_periods;
  logic         tone_out;
  logic [2:0]   held_note;

  int n_checks;
  int n_fail;
  int hp_val [8];
  string scen;

  // behavioural reference state
  int m_busy, m_j, m_note, m_dur;

  tone_player i_tone_player (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_note     (req_note),
    .req_ready    (req_ready),
    .dur_cycles   (dur_cycles),
    .half_periods (half_periods),
    .tone_out     (tone_out),
    .held_note    (held_note)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d t=%0t",
               req, scen, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_j = 0; m_note = 0;
    end else if (m_busy == 0) begin
      if (req_valid) begin
        m_busy = 1; m_j = 0; m_note = int'(req_note);
      end
    end else begin
      m_j++;
      if (m_j >= m_dur) m_busy = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int p, et;
      p  = (m_note == 0) ? 1 : ((hp_val[m_note] == 0) ? 1 : hp_val[m_note]);
      et = (m_busy != 0 && m_note != 0) ? ((m_j / p) % 2) : 0;
      check(req_ready == (m_busy == 0), "R2", "ready", int'(req_ready), int'(m_busy == 0));
      check(tone_out == et[0], "R5", "tone", int'(tone_out), et);
      check(int'(held_note) == m_note, "R8", "held", int'(held_note), m_note);
    end
  end

  task automatic do_reset(input int dur);
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    dur_cycles = 16'(dur);
    m_dur = (dur == 0) ? 1 : dur;
    @(negedge clk);
    scen = "R9";
    check(req_ready == 1'b1, "R9", "reset ready", int'(req_ready), 1);
    check(tone_out == 1'b0, "R9", "reset tone", int'(tone_out), 0);
    check(held_note == 3'd0, "R9", "reset held", int'(held_note), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input int n);
    req_valid = 1'b1;
    req_note  = 3'(n);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; scen = "init";
    hp_val = '{0, 3, 4, 5, 2, 7, 6, 1};
    for (int i = 1; i < 8; i++) half_periods[(i-1)*16 +: 16] = 16'(hp_val[i]);
    rst_n = 1'b0; req_valid = 1'b0; req_note = 3'd0; dur_cycles = 16'd20; m_dur = 20;
    #1;
    do_reset(20);
    repeat (2) @(negedge clk);

    scen = "R1"; send(1); wait_idle();
    scen = "R5"; send(3); wait_idle();
    scen = "R5"; send(7); wait_idle();
    scen = "R4"; send(0); wait_idle();

    // R3: busy-time requests with other numbers are ignored
    scen = "R3"; send(5);
    req_valid = 1'b1; req_note = 3'd2;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();

    // R6: valid held high, notes issued back to back
    scen = "R6";
    send(4); send(6); send(2); wait_idle();

    // R7: idle with valid low for a while
    scen = "R7"; repeat (6) @(negedge clk);

    // R2: zero duration behaves like one cycle
    do_reset(0);
    scen = "R2"; send(2); send(7); send(0); wait_idle();

    do_reset(1);
    scen = "R2"; send(6); wait_idle();

    do_reset(33);
    scen = "R5"; send(5); send(3); wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule